// File: doc/BRIEF.md
# Watchdog Timer with Protected Disable

This block is a system watchdog. A free-running counter in a slow, separate watchdog clock domain advances while the watchdog is on. If software does not restart it before the selected timeout, the block raises a one-cycle system reset pulse in the watchdog clock domain. Software restarts the count with a single-cycle restart strobe, which plays the role of a watchdog-restart instruction.

Configuration sits in one control register in the register-bus clock domain. The bus is minimal: a write strobe with write data, and read data that always shows the register. The register holds an enable bit, a three-bit timeout select and a turn-off-enable bit. Turning the watchdog off takes two steps. First, one write sets enable and turn-off-enable together. A second write, which clears enable, must follow within four bus cycles. A stray single write therefore cannot disable the watchdog.

The enable level, the timeout select and the restart events cross into the watchdog domain through synchronizers. The shortest timeout is 2^BASE_LOG2 watchdog cycles. The default is 16K cycles.

Top module: `wdt_protected`

## Requirements
- R1: After reset, rd_data reads 0x00 and wdt_reset stays low.
- R2: rd_data bit 4 is turn-off-enable, bit 3 is enable, and bits 2..0 are the timeout select. Bits 7..5 always read 0. A write stores bits 2..0 of wr_data as the select.
- R3: While enabled and not restarted, wdt_reset pulses every 2^(BASE_LOG2+select) watchdog-clock cycles. Select 0 gives the shortest period, and each step up doubles it.
- R4: A restart strobe clears the timeout count. Restarts spaced well inside the timeout prevent every reset pulse. Pulses resume once the restarts stop.
- R5: Turn-off-enable is set only by a write with wr_data bits 4 and 3 both 1. It reads 1 for the four bus cycles after that write and reads 0 after that.
- R6: A write with wr_data bit 3 = 0 leaves enable unchanged while turn-off-enable is clear.
- R7: A write clearing enable on any of the four bus cycles after the opening write turns the watchdog off, and no further pulses follow. The same write on the fifth cycle is ignored, and pulses continue.
- R8: A write with wr_data bit 3 = 1 sets enable at any time, with no preceding sequence.
- R9: A change of select does not clear the count. If the count already exceeds the new limit, the pulse comes on the next comparison in the watchdog domain.
- R10: Each wdt_reset pulse lasts one watchdog-clock cycle, and the count restarts from zero after it. No pulse is produced while the synchronized enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 5 | Write data for the implemented bits 4..0 |
| rd_data | output | 8 | Control register contents, reserved bits zero |
| restart | input | 1 | Single-cycle restart strobe, bus clock domain |
| wdt_clk | input | 1 | Slow watchdog clock |
| wdt_reset | output | 1 | One-cycle reset pulse, watchdog clock domain |

## Verification
The assertions assume two things about restart and writes. Restart pulses on clk arrive no faster than the watchdog domain can resolve the toggle. The select is steady long enough for all its bits to cross together. The stimulus respects both. It spaces restarts by twelve bus cycles and changes the select only through isolated writes, followed by waits of many watchdog cycles. Pulse periods are measured between consecutive pulses, so the synchronizer latency after a configuration change never enters a compared value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int SEL_W   = 3;
    localparam int CTRL_W  = 8;
    localparam int WIN_LEN = 4;
    localparam int TOE_BIT = 4;
    localparam int EN_BIT  = 3;

    typedef struct packed {
        logic             toe;
        logic             en;
        logic [SEL_W-1:0] sel;
    } wdt_ctrl_t;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
    import wdt_pkg::*;
#(
    parameter int WINDOW = WIN_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [EN_BIT+1:0] wr_data,
    output wdt_ctrl_t         ctrl_o,
    output logic [CTRL_W-1:0] rd_data
);
    localparam int WIN_W = $clog2(WINDOW + 1);

    typedef struct packed {
        wdt_ctrl_t        ctrl;
        logic [WIN_W-1:0] win;
    } st_t;

    st_t s_d, s_q;
    logic open_wr;

    always_comb begin
        s_d     = s_q;
        open_wr = wr_en && wr_data[TOE_BIT] && wr_data[EN_BIT];
        if (s_q.ctrl.toe) begin
            if (s_q.win == '0) s_d.ctrl.toe = 1'b0;
            else               s_d.win      = s_q.win - 1'b1;
        end
        if (wr_en) begin
            s_d.ctrl.sel = wr_data[SEL_W-1:0];
            if (wr_data[EN_BIT])    s_d.ctrl.en = 1'b1;
            else if (s_q.ctrl.toe)  s_d.ctrl.en = 1'b0;
        end
        if (open_wr) begin
            s_d.ctrl.toe = 1'b1;
            s_d.win      = WIN_W'(WINDOW - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rd_data                 = '0;
        rd_data[TOE_BIT]        = s_q.ctrl.toe;
        rd_data[EN_BIT]         = s_q.ctrl.en;
        rd_data[SEL_W-1:0]      = s_q.ctrl.sel;
    end

    assign ctrl_o = s_q.ctrl;

    // R5
    toe_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.toe && s_q.win == '0 && !open_wr) |=> !s_q.ctrl.toe);

    // R6
    en_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ctrl.en && !s_q.ctrl.toe) |=> s_q.ctrl.en);
endmodule

// File: rtl/wdt_cdc.sv
module wdt_cdc
    import wdt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             wdt_clk,
    input  logic             rst_n,
    input  logic             restart_i,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             en_o,
    output logic [SEL_W-1:0] sel_o,
    output logic             kick_o
);
    localparam int VW = SEL_W + 2;

    logic tgl_d, tgl_q;
    logic [STAGES-1:0][VW-1:0] sync_d, sync_q;
    logic prev_d, prev_q;

    always_comb tgl_d = tgl_q ^ restart_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= tgl_d;
    end

    always_comb begin
        sync_d[0] = {tgl_q, en_i, sel_i};
        for (int i = 1; i < STAGES; i++) sync_d[i] = sync_q[i-1];
        prev_d = sync_q[STAGES-1][VW-1];
    end

    always_ff @(posedge wdt_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign en_o   = sync_q[STAGES-1][SEL_W];
    assign sel_o  = sync_q[STAGES-1][SEL_W-1:0];
    assign kick_o = sync_q[STAGES-1][VW-1] ^ prev_q;
endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 14
) (
    input  logic             wdt_clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             kick_i,
    output logic             pulse_o
);
    localparam int CNT_W = BASE_LOG2 + (1 << SEL_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
    } st_t;

    st_t s_d, s_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        last_cnt = (CNT_W'(1) << (BASE_LOG2 + 32'(sel_i))) - CNT_W'(1);
        s_d      = '0;
        if (en_i && !kick_i) begin
            if (s_q.cnt >= last_cnt) s_d.pulse = 1'b1;
            else                     s_d.cnt   = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge wdt_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_o = s_q.pulse;

    // R10
    pulse_width_chk: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        s_q.pulse |=> !s_q.pulse);

    // R10
    pulse_clear_chk: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        s_q.pulse |-> s_q.cnt == '0);

    // R10
    no_pulse_off_chk: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        !en_i |=> !s_q.pulse);

    // R4
    kick_clear_chk: assert property (@(posedge wdt_clk) disable iff (!rst_n)
        kick_i |=> (s_q.cnt == '0 && !s_q.pulse));
endmodule

// File: rtl/wdt_protected.sv
module wdt_protected
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2   = 14,
    parameter int SYNC_STAGES = 2,
    parameter int WINDOW      = WIN_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [EN_BIT+1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              restart,
    input  logic              wdt_clk,
    output logic              wdt_reset
);
    wdt_ctrl_t        ctrl;
    logic             en_s;
    logic [SEL_W-1:0] sel_s;
    logic             kick;

    wdt_ctrl_reg #(.WINDOW(WINDOW)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_o  (ctrl),
        .rd_data (rd_data)
    );

    wdt_cdc #(.STAGES(SYNC_STAGES)) u_cdc (
        .clk       (clk),
        .wdt_clk   (wdt_clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .en_i      (ctrl.en),
        .sel_i     (ctrl.sel),
        .en_o      (en_s),
        .sel_o     (sel_s),
        .kick_o    (kick)
    );

    wdt_timeout #(.BASE_LOG2(BASE_LOG2)) u_tmo (
        .wdt_clk (wdt_clk),
        .rst_n   (rst_n),
        .en_i    (en_s),
        .sel_i   (sel_s),
        .kick_i  (kick),
        .pulse_o (wdt_reset)
    );
endmodule

// File: tb/tb_wdt_protected.sv
module tb_wdt_protected;
    logic       clk = 1'b0;
    logic       wdt_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       restart = 1'b0;
    logic       wdt_reset;

    always #4  clk = ~clk;
    always #10 wdt_clk = ~wdt_clk;

    wdt_protected #(.BASE_LOG2(4)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .restart(restart), .wdt_clk(wdt_clk),
        .wdt_reset(wdt_reset)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    int wcyc = 0, last_pulse = 0, last_gap = 0, pulse_cnt = 0, run = 0, max_run = 0;

    always @(negedge wdt_clk) begin
        wcyc++;
        if (wdt_reset) begin
            run++;
            if (run > max_run) max_run = run;
            if (run == 1) begin
                last_gap   = wcyc - last_pulse;
                last_pulse = wcyc;
                pulse_cnt++;
            end
        end else begin
            run = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares register readback 1 ns after each bus negedge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(rd_data === it.exp, it.tag, int'(rd_data), int'(it.exp));
            end
        end
    end

    task automatic expect_reg(input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic write_reg(input logic [4:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wcycles(input int n);
        repeat (n) @(negedge wdt_clk);
    endtask

    task automatic wait_pulses(input int n, input int maxcyc, output bit got, output int used);
        int start;
        start = pulse_cnt;
        got   = 1'b0;
        used  = 0;
        for (int i = 0; i < maxcyc; i++) begin
            @(negedge wdt_clk);
            used++;
            if (pulse_cnt >= start + n) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit got;
        int used;
        int p0;

        idle(5);
        rst_n = 1'b1;
        idle(1);
        expect_reg(8'h00, "R1 reset value");
        wcycles(60);
        check(pulse_cnt == 0, "R1 no pulse after reset", pulse_cnt, 0);

        // R8 enable without any sequence, R2 field positions
        idle(1);
        write_reg(5'h08);
        expect_reg(8'h08, "R8 enable set directly");
        wait_pulses(3, 120, got, used);
        check(got, "R3 pulses occur", int'(got), 1);
        check(last_gap == 16, "R3 period select 0", last_gap, 16);
        check(max_run == 1, "R10 pulse width", max_run, 1);

        write_reg(5'h0A);
        expect_reg(8'h0A, "R2 select readback");
        wait_pulses(2, 400, got, used);
        check(last_gap == 64, "R3 period select 2", last_gap, 64);

        write_reg(5'h08);
        expect_reg(8'h08, "R2 select back to 0");

        // R4 restarts hold off reset
        for (int k = 0; k < 43; k++) begin
            if (k == 3) p0 = pulse_cnt;
            restart = 1'b1;
            @(negedge clk);
            restart = 1'b0;
            idle(11);
        end
        check(pulse_cnt == p0, "R4 restarts prevent reset", pulse_cnt, p0);
        wait_pulses(1, 40, got, used);
        check(got, "R4 pulses resume", int'(got), 1);

        // R6 clear of enable ignored without window; R5 turn-off alone does not open it
        write_reg(5'h00);
        expect_reg(8'h08, "R6 enable kept");
        write_reg(5'h10);
        expect_reg(8'h08, "R5 turn-off alone ignored");

        // R5 window length
        write_reg(5'h18);
        expect_reg(8'h18, "R5 window open");
        idle(3);
        expect_reg(8'h18, "R5 window fourth cycle");
        idle(1);
        expect_reg(8'h08, "R5 window closed");

        // R7 late disable ignored
        write_reg(5'h18);
        idle(4);
        write_reg(5'h00);
        expect_reg(8'h08, "R7 late clear ignored");
        wait_pulses(1, 40, got, used);
        check(got, "R7 still running after late clear", int'(got), 1);

        // R9 lowering select with count past new limit
        write_reg(5'h0B);
        wait_pulses(1, 300, got, used);
        check(got, "R9 pulse at select 3", int'(got), 1);
        wcycles(100);
        write_reg(5'h08);
        wait_pulses(1, 40, got, used);
        check(got && used <= 8, "R9 immediate fire after select drop", used, 8);

        // R7 disable inside window
        write_reg(5'h18);
        idle(3);
        write_reg(5'h00);
        expect_reg(8'h00, "R7 disabled in window");
        wcycles(10);
        p0 = pulse_cnt;
        wcycles(100);
        check(pulse_cnt == p0, "R7 R10 no pulse when disabled", pulse_cnt, p0);

        // R8 re-enable at select 4
        write_reg(5'h0C);
        expect_reg(8'h0C, "R8 re-enable");
        wait_pulses(2, 600, got, used);
        check(got && last_gap == 256, "R8 R3 period select 4", last_gap, 256);

        idle(4);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule